// File: doc/BRIEF.md
# Dual-Output Vector Unzip Permuter

This block splits two source vectors into their even-indexed and odd-indexed elements in one pass and delivers both results together. The even result packs every even element of source A into its lower half and every even element of source B directly above that. The odd result does the same with the odd elements. The element width is chosen per operation: a 2-bit size code selects 8, 16, 32 or 64 bits, and a separate wide-element flag forces 128-bit elements whatever the size code says.

The active vector length is given per operation as a count of 128-bit units and may be anything from one unit up to the synthesised maximum. Bits above the active length are driven to zero. Operations that cannot be carried out are flagged rather than executed: a zero or oversize length, or a length too short to hold one pair of elements. The destination is an even/odd register pair. The block turns a destination field into the pair's base index (the field times two) and the second index (base plus one) for the register file outside it.

A request is sampled when `in_valid` is high and its result appears on the registered outputs one clock later.

Top module: `vec_unzip_pair`

## Requirements
- R1: Size code 0, 1, 2 and 3 select 8, 16, 32 and 64-bit elements respectively (width = 8 << code) when `wide_mode` is 0.
- R2: With `wide_mode` = 1 the element width is 128 bits, whatever the value of `size_code`.
- R3: With element width w, active length L = `vl_units`*128 and pairs P = L/(2w), `res_even` element p (bits p*w upward) equals `src_a` element 2p, and `res_even` element P+p equals `src_b` element 2p, for p in 0..P-1.
- R4: Under the same indexing, `res_odd` element p equals `src_a` element 2p+1 and `res_odd` element P+p equals `src_b` element 2p+1.
- R5: All bits of `res_even` and `res_odd` at or above the active length L are zero.
- R6: A request is illegal when `vl_units` is 0, when it exceeds MAX_VL/128, or when L is less than twice the element width. 128-bit elements are also illegal whenever MAX_VL is below 256. An illegal request gives `out_illegal` = 1, `out_valid` = 0 and both results all-zero one cycle later.
- R7: For a legal request, `dst_base` equals `dst_field`*2 and `dst_next` equals `dst_field`*2+1 one cycle later.
- R8: A legal request with `in_valid` high gives `out_valid` = 1 with `out_illegal` = 0 on the following cycle.
- R9: After reset, and in any cycle that follows one with `in_valid` low, `out_valid`, `out_illegal`, both results and both destination indices are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| size_code | input | 2 | Element width code (8 << code bits) |
| wide_mode | input | 1 | Force 128-bit elements |
| vl_units | input | $clog2(MAX_VL/128)+1 | Active length in 128-bit units |
| dst_field | input | DF_W | Encoded destination pair field |
| src_a | input | MAX_VL | First source vector |
| src_b | input | MAX_VL | Second source vector |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Request was rejected |
| dst_base | output | DF_W+1 | First destination register index |
| dst_next | output | DF_W+1 | Second destination register index |
| res_even | output | MAX_VL | Even-element result |
| res_odd | output | MAX_VL | Odd-element result |

## Verification
Every size code is swept with both values of the wide flag across every length code from zero to past the maximum. Each combination uses one structured pattern with all bytes distinct and two random patterns. The structured pattern catches a design that takes source B elements from the wrong offset or places them at a fixed half instead of at P. Such a design would put stray bytes into the upper result or leave gaps in it. The wide flag is driven with several size codes, which catches a design that lets the size code leak into wide mode. A length of one unit with 128-bit elements, and lengths of zero or above the maximum, must come back flagged and zeroed. A design that only checks one bound would emit data for these. Idle cycles after each request confirm that the outputs fall back to zero.

// File: rtl/unzip_pkg.sv
package unzip_pkg;

    localparam int UNIT_BITS = 128;
    localparam int NUM_WIDTHS = 5;
    localparam int WIDE_SEL = 4;

    // Element width in bits for a width selector (0..4).
    function automatic int width_of(input int sel);
        return 8 << sel;
    endfunction

endpackage

// File: rtl/unzip_legal.sv
module unzip_legal
    import unzip_pkg::*;
#(
    parameter int MAX_VL = 512,
    parameter int UW     = 3
) (
    input  logic [UW-1:0] vl_units,
    input  logic [2:0]    width_sel,
    output logic          illegal
);
    localparam int MAX_UNITS = MAX_VL / UNIT_BITS;
    localparam bit WIDE_OK   = (MAX_VL >= 256);

    int vl_bits;
    int ew;

    always_comb begin
        vl_bits = int'(vl_units) * UNIT_BITS;
        ew      = width_of(int'(width_sel));
        illegal = 1'b0;
        if (vl_units == '0)                       illegal = 1'b1;
        if (int'(vl_units) > MAX_UNITS)           illegal = 1'b1;
        if (vl_bits < 2 * ew)                     illegal = 1'b1;
        if ((width_sel == 3'(WIDE_SEL)) && !WIDE_OK) illegal = 1'b1;
    end

endmodule

// File: rtl/unzip_perm.sv
module unzip_perm
    import unzip_pkg::*;
#(
    parameter int MAX_VL = 512,
    parameter int UW     = 3,
    parameter int EW     = 8
) (
    input  logic [UW-1:0]     vl_units,
    input  logic [MAX_VL-1:0] src_a,
    input  logic [MAX_VL-1:0] src_b,
    output logic [MAX_VL-1:0] even_o,
    output logic [MAX_VL-1:0] odd_o
);
    localparam int N         = MAX_VL / EW;
    localparam int HALF      = N / 2;
    localparam int MAX_UNITS = MAX_VL / UNIT_BITS;

    int pairs;

    always_comb begin
        if (int'(vl_units) > MAX_UNITS) pairs = 0;
        else                            pairs = (int'(vl_units) * UNIT_BITS) / (2 * EW);
    end

    always_comb begin
        even_o = '0;
        odd_o  = '0;
        // lower half from source A
        for (int k = 0; k < HALF; k++) begin
            if (k < pairs) begin
                even_o[k*EW +: EW] = src_a[(2*k)*EW   +: EW];
                odd_o[k*EW +: EW]  = src_a[(2*k+1)*EW +: EW];
            end
        end
        // upper half from source B, starting at element index pairs
        for (int j = 0; j < HALF; j++) begin
            if (j < pairs) begin
                even_o[(pairs+j)*EW +: EW] = src_b[(2*j)*EW   +: EW];
                odd_o[(pairs+j)*EW +: EW]  = src_b[(2*j+1)*EW +: EW];
            end
        end
    end

endmodule

// File: rtl/vec_unzip_pair.sv
module vec_unzip_pair
    import unzip_pkg::*;
#(
    parameter int MAX_VL = 512,
    parameter int DF_W   = 4,
    localparam int UW    = $clog2(MAX_VL / 128) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        size_code,
    input  logic              wide_mode,
    input  logic [UW-1:0]     vl_units,
    input  logic [DF_W-1:0]   dst_field,
    input  logic [MAX_VL-1:0] src_a,
    input  logic [MAX_VL-1:0] src_b,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [DF_W:0]     dst_base,
    output logic [DF_W:0]     dst_next,
    output logic [MAX_VL-1:0] res_even,
    output logic [MAX_VL-1:0] res_odd
);
    localparam int MAX_UNITS = MAX_VL / UNIT_BITS;

    typedef struct packed {
        logic              vld;
        logic              ill;
        logic [DF_W:0]     base;
        logic [MAX_VL-1:0] ev;
        logic [MAX_VL-1:0] od;
    } st_t;

    st_t st_d, st_q;

    logic [2:0] width_sel;
    logic       illegal_c;
    logic [MAX_VL-1:0] ev_w [NUM_WIDTHS];
    logic [MAX_VL-1:0] od_w [NUM_WIDTHS];

    assign width_sel = wide_mode ? 3'(WIDE_SEL) : {1'b0, size_code};

    unzip_legal #(.MAX_VL(MAX_VL), .UW(UW)) u_legal (
        .vl_units  (vl_units),
        .width_sel (width_sel),
        .illegal   (illegal_c)
    );

    for (genvar gi = 0; gi < NUM_WIDTHS; gi++) begin : g_width
        localparam int EW = 8 << gi;
        if (2 * EW <= MAX_VL) begin : g_on
            unzip_perm #(.MAX_VL(MAX_VL), .UW(UW), .EW(EW)) u_perm (
                .vl_units (vl_units),
                .src_a    (src_a),
                .src_b    (src_b),
                .even_o   (ev_w[gi]),
                .odd_o    (od_w[gi])
            );
        end else begin : g_off
            assign ev_w[gi] = '0;
            assign od_w[gi] = '0;
        end
    end

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            if (illegal_c) begin
                st_d.ill = 1'b1;
            end else begin
                st_d.vld  = 1'b1;
                st_d.base = {dst_field, 1'b0};
                st_d.ev   = ev_w[width_sel];
                st_d.od   = od_w[width_sel];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_illegal = st_q.ill;
    assign dst_base    = st_q.base;
    assign dst_next    = st_q.vld ? (st_q.base | (DF_W+1)'(1)) : '0;
    assign res_even    = st_q.ev;
    assign res_odd     = st_q.od;

    function automatic logic [MAX_VL-1:0] active_mask(input logic [UW-1:0] u);
        logic [MAX_VL-1:0] m;
        m = '0;
        for (int b = 0; b < MAX_VL; b++)
            if (b < int'(u) * UNIT_BITS) m[b] = 1'b1;
        return m;
    endfunction

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !illegal_c) |=> (out_valid && !out_illegal));

    p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_valid && res_even == '0 && res_odd == '0));

    p_pair_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !illegal_c) |=> (dst_base == {$past(dst_field), 1'b0}
                                       && dst_next == {$past(dst_field), 1'b1}));

    p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !illegal_c) |=> (((res_even | res_odd) & ~active_mask($past(vl_units))) == '0));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_illegal && res_even == '0 && dst_base == '0));

    p_oversize_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(vl_units) > MAX_UNITS) |=> out_illegal);

endmodule

// File: tb/sim_vec_unzip_pair.sv
module sim_vec_unzip_pair;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_VL = 512;
    localparam int DF_W = 4;
    localparam int UW = $clog2(MAX_VL / 128) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] size_code = '0;
    logic wide_mode = 1'b0;
    logic [UW-1:0] vl_units = '0;
    logic [DF_W-1:0] dst_field = '0;
    logic [MAX_VL-1:0] src_a = '0, src_b = '0;
    logic out_valid, out_illegal;
    logic [DF_W:0] dst_base, dst_next;
    logic [MAX_VL-1:0] res_even, res_odd;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_unzip_pair #(.MAX_VL(MAX_VL), .DF_W(DF_W)) u0 (
        .clk, .rst_n, .in_valid, .size_code, .wide_mode, .vl_units, .dst_field,
        .src_a, .src_b, .out_valid, .out_illegal, .dst_base, .dst_next,
        .res_even, .res_odd
    );

    task automatic chk(input string req, input string what, input logic [MAX_VL-1:0] act,
                       input logic [MAX_VL-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input int sz, input bit wide, input int units, input int fld,
                           input logic [MAX_VL-1:0] a, input logic [MAX_VL-1:0] b);
        int ew, vl, pairs;
        bit ill;
        logic [MAX_VL-1:0] ee, eo;
        string rq;
        ew = wide ? 128 : (8 << sz);   // R1 and R2 width rule
        vl = units * 128;
        ill = (units == 0) || (units > MAX_VL/128) || (vl < 2*ew);
        ee = '0; eo = '0;
        if (!ill) begin
            pairs = vl / (2*ew);
            for (int p = 0; p < pairs; p++)
                for (int t = 0; t < ew; t++) begin
                    ee[p*ew + t]         = a[(2*p)*ew + t];
                    eo[p*ew + t]         = a[(2*p+1)*ew + t];
                    ee[(pairs+p)*ew + t] = b[(2*p)*ew + t];
                    eo[(pairs+p)*ew + t] = b[(2*p+1)*ew + t];
                end
        end
        rq = wide ? "R2" : "R1";
        @(negedge clk);
        in_valid = 1'b1; size_code = 2'(sz); wide_mode = wide; vl_units = UW'(units);
        dst_field = DF_W'(fld); src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        if (ill) begin
            chk("R6", "illegal flag", MAX_VL'(out_illegal), MAX_VL'(1));
            chk("R6", "valid suppressed", MAX_VL'(out_valid), '0);
            chk("R6", "results zero", res_even | res_odd, '0);
        end else begin
            chk("R8", "valid", MAX_VL'({out_valid, out_illegal}), MAX_VL'(2'b10));
            chk("R3", {rq, " even result"}, res_even, ee);
            chk("R4", {rq, " odd result"}, res_odd, eo);
            chk("R5", "tail zero", (res_even | res_odd) & ~((ee | eo) | ({MAX_VL{1'b1}} >> (MAX_VL - vl))), '0);
            chk("R7", "base", MAX_VL'(dst_base), MAX_VL'(fld * 2));
            chk("R7", "next", MAX_VL'(dst_next), MAX_VL'(fld * 2 + 1));
        end
        @(negedge clk);
        // R9: idle cycle after request
        chk("R9", "idle", MAX_VL'({out_valid, out_illegal, dst_base, dst_next}) | res_even | res_odd, '0);
    endtask

    initial begin
        logic [MAX_VL-1:0] pa, pb;
        int fld;
        for (int i = 0; i < MAX_VL/8; i++) begin
            pa[i*8 +: 8] = 8'(i);
            pb[i*8 +: 8] = 8'(i + 64);
        end
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "reset", MAX_VL'({out_valid, out_illegal, dst_base, dst_next}) | res_even | res_odd, '0);
        rst_n = 1'b1;
        fld = 0;
        for (int sz = 0; sz < 4; sz++)
            for (int w = 0; w < 2; w++)
                for (int u = 0; u < (1 << UW); u++)
                    for (int pat = 0; pat < 3; pat++) begin
                        logic [MAX_VL-1:0] ra, rb;
                        for (int q = 0; q < MAX_VL/32; q++) begin
                            ra[q*32 +: 32] = $urandom;
                            rb[q*32 +: 32] = $urandom;
                        end
                        fld = (fld + 3) % (1 << DF_W);
                        if (pat == 0) run_one(sz, w[0], u, fld, pa, pb);
                        else          run_one(sz, w[0], u, fld, ra, rb);
                    end
        // R6: 128-bit elements at minimum length, explicit corner
        run_one(3, 1'b1, 1, 15, pa, pb);
        // R2: 128-bit elements at full length with each size code
        for (int sz = 0; sz < 4; sz++) run_one(sz, 1'b1, 4, sz, pb, pa);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog timeout actual=hung expected=done");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule